// File: doc/BRIEF.md
# Type-0 Function Configuration Header

This block stores the standard 64-byte configuration header of a single device function. A host-side agent presents one access per cycle: an offset, a size of 1, 2 or 4 bytes, a write flag and right-aligned write data. One cycle later the block acknowledges it, returns right-aligned little-endian read data, and flags an error if the access was illegal. Identification, class, interrupt pin and the grant and latency limits come from parameters and cannot be written.

Six base address registers and one expansion ROM base register follow the usual sizing handshake. Software writes an all-ones probe and reads back a mask that shows the aperture. Each BAR has a fixed aperture size set by a parameter, and it is an I/O or a memory BAR according to bit 0 of its reset value. A separate address port compares an incoming address with every programmed aperture and reports one registered hit bit per BAR. Each hit is gated by the matching enable bit in the command register.

Top module: `cfg_header`

## Requirements
- R1: After reset, the read-only fields read their parameter values at the standard offsets: vendor 0x00, device 0x02, revision 0x08, class bytes 0x09..0x0B, subsystem IDs 0x2C/0x2E, interrupt pin 0x3D, minimum grant 0x3E, maximum latency 0x3F. Command, status, cache line size, latency timer and interrupt line read 0. Each BAR reads its parameter reset value.
- R2: A legal read of N bytes at offset O returns byte O in bits 7:0, byte O+k in bits 8k+7:8k, and zero above byte N-1. Reserved offsets read 0.
- R3: Byte writes are stored only at 0x3C (interrupt line), 0x0C (cache line size) and 0x0D (latency timer). Byte writes at any other legal offset change nothing and raise no error.
- R4: A 2-byte write at 0x04 loads the command register and a 2-byte write at 0x06 loads the status register. A 4-byte write at 0x04 loads the command register from data bits 15:0 and leaves status unchanged.
- R5: A 4-byte write of 0xFFFFFFFF to a BAR (0x10 + 4i, i = 0..5) makes it read ~(size-1) in its address bits while its low type bits keep their value.
- R6: Any other 4-byte BAR write stores the data outside the low type field and keeps the type field. An I/O BAR (bit 0 = 1) has type field bits 1:0; a memory BAR has type field bits 3:0.
- R7: A 4-byte write of 0xFFFFFFFE at 0x30 makes the ROM base read 0xFFFFFFFF. Any other 4-byte write there is stored unchanged.
- R8: An access whose offset plus size exceeds 0x40 sets the error flag, returns read data 0 and changes no register.
- R9: An access with a size other than 1, 2 or 4 sets the error flag, returns read data 0 and changes no register.
- R10: Every valid access is acknowledged on the next cycle, with the error flag in that same cycle. Without a valid access, the acknowledge and error outputs are 0.
- R11: One cycle after an address is presented, hit bit i is 1 exactly when BAR i has a nonzero base and the address lies in [base, base+size). The space input must also match the BAR type (1 = I/O), and the command enable for that type must be set (bit 0 for I/O, bit 1 for memory).
- R12: 4-byte writes to offsets other than 0x04, the BARs and 0x30 are accepted without error and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 8 | Byte offset into the header |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Right-aligned write data |
| acc_ack | output | 1 | Registered acknowledge |
| acc_err | output | 1 | Registered illegal-access flag |
| acc_rdata | output | 32 | Registered right-aligned read data |
| hit_addr | input | 32 | Address to decode against the BARs |
| hit_io | input | 1 | 1 = address is in I/O space |
| bar_hit | output | 6 | Registered per-BAR hit flags |

## Verification
The properties assume that the parameterised aperture sizes are powers of two and at least 16 bytes. They also assume that acc_size and acc_offset are only meaningful while acc_valid is high. The stimulus keeps every aperture at those sizes and drives all request fields together with the valid strobe. It also presents hit addresses only while the command register holds a known value, so that each hit result follows from one command setting.

// File: rtl/cfgh_pkg.sv
`timescale 1ns/1ps
package cfgh_pkg;
  localparam int NUM_BAR    = 6;
  localparam int HDR_BYTES  = 64;
  localparam int HDR_DWORDS = HDR_BYTES / 4;
  localparam int DW_BAR0    = 4;
  localparam int DW_CIS     = 10;
  localparam int DW_SUBSYS  = 11;
  localparam int DW_ROM     = 12;
  localparam int DW_INTR    = 15;
  localparam logic [7:0] OFF_CMD  = 8'h04;
  localparam logic [7:0] OFF_STS  = 8'h06;
  localparam logic [7:0] OFF_CLS  = 8'h0C;
  localparam logic [7:0] OFF_LAT  = 8'h0D;
  localparam logic [7:0] OFF_BAR0 = 8'h10;
  localparam logic [7:0] OFF_ROM  = 8'h30;
  localparam logic [7:0] OFF_LINE = 8'h3C;
  localparam logic [31:0] ROM_PROBE = 32'hFFFF_FFFE;

  function automatic logic [31:0] low_type_mask(input logic is_io);
    return is_io ? 32'h0000_0003 : 32'h0000_000F;
  endfunction
endpackage

// File: rtl/cfgh_decode.sv
`timescale 1ns/1ps
module cfgh_decode import cfgh_pkg::*; (
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [7:0]         acc_offset,
  input  logic [2:0]         acc_size,
  output logic               illegal,
  output logic               we_line,
  output logic               we_cls,
  output logic               we_lat,
  output logic               we_cmd,
  output logic               we_sts,
  output logic [NUM_BAR-1:0] we_bar,
  output logic               we_rom
);
  logic size_ok, range_ok, wr_ok, sz1, sz2, sz4;

  assign sz1      = (acc_size == 3'd1);
  assign sz2      = (acc_size == 3'd2);
  assign sz4      = (acc_size == 3'd4);
  assign size_ok  = sz1 | sz2 | sz4;
  assign range_ok = ({1'b0, acc_offset} + {6'b0, acc_size}) <= 9'(HDR_BYTES);
  assign illegal  = !(size_ok && range_ok);
  assign wr_ok    = acc_valid && acc_write && !illegal;

  assign we_line = wr_ok && sz1 && (acc_offset == OFF_LINE);
  assign we_cls  = wr_ok && sz1 && (acc_offset == OFF_CLS);
  assign we_lat  = wr_ok && sz1 && (acc_offset == OFF_LAT);
  assign we_cmd  = wr_ok && (sz2 || sz4) && (acc_offset == OFF_CMD);
  assign we_sts  = wr_ok && sz2 && (acc_offset == OFF_STS);
  assign we_rom  = wr_ok && sz4 && (acc_offset == OFF_ROM);

  for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar_we
    assign we_bar[i] = wr_ok && sz4 && (acc_offset == 8'(int'(OFF_BAR0) + 4 * i));
  end
endmodule

// File: rtl/cfgh_bar.sv
`timescale 1ns/1ps
module cfgh_bar import cfgh_pkg::*; #(
  parameter logic [31:0] SIZE = 32'h100,
  parameter logic [31:0] INIT = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        io_en,
  input  logic        mem_en,
  input  logic [31:0] hit_addr,
  input  logic        hit_io,
  output logic [31:0] bar_q,
  output logic        hit_q
);
  localparam logic [31:0] SZM1 = SIZE - 32'd1;
  localparam logic [31:0] LOWM = low_type_mask(INIT[0]);

  logic        is_io, space_en, hit_c;
  logic [31:0] base;

  assign is_io    = bar_q[0];
  assign space_en = is_io ? io_en : mem_en;
  assign base     = bar_q & ~SZM1 & ~LOWM;
  assign hit_c    = (base != 32'd0) && (hit_io == is_io) && space_en &&
                    ((hit_addr & ~SZM1) == base);

  always_ff @(posedge clk) begin
    if (rst) begin
      bar_q <= INIT;
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit_c;
      if (wr_en) begin
        if (wdata == 32'hFFFF_FFFF)
          bar_q <= (~SZM1 & ~LOWM) | (bar_q & LOWM);
        else
          bar_q <= (wdata & ~LOWM) | (bar_q & LOWM);
      end
    end
  end

  assert_type_keep_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(bar_q & LOWM));
  assert_probe_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata == 32'hFFFF_FFFF) |=> ((bar_q | SZM1 | LOWM) == 32'hFFFF_FFFF));
  assert_hit_gated_R11: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> $past(hit_io == bar_q[0] && (bar_q[0] ? io_en : mem_en)));
endmodule

// File: rtl/cfgh_rom.sv
`timescale 1ns/1ps
module cfgh_rom import cfgh_pkg::*; #(
  parameter logic [31:0] INIT = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rom_q
);
  always_ff @(posedge clk) begin
    if (rst)
      rom_q <= INIT;
    else if (wr_en)
      rom_q <= (wdata == ROM_PROBE) ? 32'hFFFF_FFFF : wdata;
  end

  assert_rom_probe_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata == ROM_PROBE) |=> (rom_q == 32'hFFFF_FFFF));
  assert_rom_plain_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata != ROM_PROBE) |=> (rom_q == $past(wdata)));
endmodule

// File: rtl/cfg_header.sv
`timescale 1ns/1ps
module cfg_header import cfgh_pkg::*; #(
  parameter logic [15:0] VENDOR     = 16'hC0DE,
  parameter logic [15:0] DEVICE     = 16'h5A17,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter logic [7:0]  PROG_IF    = 8'h00,
  parameter logic [7:0]  SUB_CLASS  = 8'h80,
  parameter logic [7:0]  BASE_CLASS = 8'h02,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter logic [7:0]  SELF_TEST  = 8'h00,
  parameter logic [31:0] CIS_PTR    = 32'h0,
  parameter logic [15:0] SUBSYS_VEN = 16'h1234,
  parameter logic [15:0] SUBSYS_ID  = 16'h5678,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h08,
  parameter logic [7:0]  MAX_LAT    = 8'h20,
  parameter logic [31:0] ROM_INIT   = 32'h0,
  parameter logic [NUM_BAR*32-1:0] BAR_SIZE =
    {32'h80, 32'h40, 32'h20, 32'h0001_0000, 32'h0000_1000, 32'h100},
  parameter logic [NUM_BAR*32-1:0] BAR_INIT =
    {32'h0, 32'h0, 32'h0, 32'h8, 32'h0, 32'h1}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [7:0]         acc_offset,
  input  logic [2:0]         acc_size,
  input  logic [31:0]        acc_wdata,
  output logic               acc_ack,
  output logic               acc_err,
  output logic [31:0]        acc_rdata,
  input  logic [31:0]        hit_addr,
  input  logic               hit_io,
  output logic [NUM_BAR-1:0] bar_hit
);
  logic [15:0] cmd_q, sts_q;
  logic [7:0]  line_q, cls_q, lat_q;
  logic [NUM_BAR-1:0][31:0] bar_val;
  logic [31:0] rom_val;
  logic        illegal, we_line, we_cls, we_lat, we_cmd, we_sts, we_rom;
  logic [NUM_BAR-1:0] we_bar;
  logic [31:0] hdr [HDR_DWORDS];
  logic [31:0] rd_c;

  cfgh_decode u_dec (
    .acc_valid (acc_valid), .acc_write (acc_write),
    .acc_offset(acc_offset), .acc_size (acc_size),
    .illegal   (illegal),   .we_line  (we_line),
    .we_cls    (we_cls),    .we_lat   (we_lat),
    .we_cmd    (we_cmd),    .we_sts   (we_sts),
    .we_bar    (we_bar),    .we_rom   (we_rom)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      sts_q  <= '0;
      line_q <= '0;
      cls_q  <= '0;
      lat_q  <= '0;
    end else begin
      if (we_cmd)  cmd_q  <= acc_wdata[15:0];
      if (we_sts)  sts_q  <= acc_wdata[15:0];
      if (we_line) line_q <= acc_wdata[7:0];
      if (we_cls)  cls_q  <= acc_wdata[7:0];
      if (we_lat)  lat_q  <= acc_wdata[7:0];
    end
  end

  for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
    cfgh_bar #(
      .SIZE(BAR_SIZE[i*32 +: 32]),
      .INIT(BAR_INIT[i*32 +: 32])
    ) u_bar (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (we_bar[i]),
      .wdata   (acc_wdata),
      .io_en   (cmd_q[0]),
      .mem_en  (cmd_q[1]),
      .hit_addr(hit_addr),
      .hit_io  (hit_io),
      .bar_q   (bar_val[i]),
      .hit_q   (bar_hit[i])
    );
  end

  cfgh_rom #(.INIT(ROM_INIT)) u_rom (
    .clk  (clk),
    .rst  (rst),
    .wr_en(we_rom),
    .wdata(acc_wdata),
    .rom_q(rom_val)
  );

  always_comb begin
    for (int d = 0; d < HDR_DWORDS; d++) hdr[d] = 32'h0;
    hdr[0] = {DEVICE, VENDOR};
    hdr[1] = {sts_q, cmd_q};
    hdr[2] = {BASE_CLASS, SUB_CLASS, PROG_IF, REVISION};
    hdr[3] = {SELF_TEST, HDR_TYPE, lat_q, cls_q};
    for (int b = 0; b < NUM_BAR; b++) hdr[DW_BAR0 + b] = bar_val[b];
    hdr[DW_CIS]    = CIS_PTR;
    hdr[DW_SUBSYS] = {SUBSYS_ID, SUBSYS_VEN};
    hdr[DW_ROM]    = rom_val;
    hdr[DW_INTR]   = {MAX_LAT, MIN_GNT, INT_PIN, line_q};
  end

  always_comb begin
    logic [5:0] idx;
    rd_c = 32'h0;
    for (int k = 0; k < 4; k++) begin
      idx = acc_offset[5:0] + 6'(k);
      if (k < int'(acc_size))
        rd_c[k*8 +: 8] = hdr[idx[5:2]][idx[1:0]*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_ack   <= 1'b0;
      acc_err   <= 1'b0;
      acc_rdata <= 32'h0;
    end else begin
      acc_ack   <= acc_valid;
      acc_err   <= acc_valid && illegal;
      acc_rdata <= (acc_valid && !acc_write && !illegal) ? rd_c : 32'h0;
    end
  end

  assert_range_err_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && ({1'b0, acc_offset} + {6'b0, acc_size} > 9'd64)) |=> acc_err);
  assert_size_err_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_size != 3'd1 && acc_size != 3'd2 && acc_size != 3'd4) |=> acc_err);
  assert_bad_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && illegal) |=>
      ($stable(cmd_q) && $stable(sts_q) && $stable(line_q) && $stable(cls_q) &&
       $stable(lat_q) && $stable(rom_val) && $stable(bar_val)));
  assert_ack_R10: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> acc_ack);
  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!acc_ack && !acc_err && acc_rdata == 32'h0));
endmodule

// File: tb/cfg_header_bench.sv
`timescale 1ns/1ps
module cfg_header_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [7:0]  acc_offset = '0;
  logic [2:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic        acc_ack, acc_err;
  logic [31:0] acc_rdata;
  logic [31:0] hit_addr = '0;
  logic        hit_io = 1'b0;
  logic [5:0]  bar_hit;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  cfg_header u_cfg_header (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_offset(acc_offset), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .acc_ack(acc_ack), .acc_err(acc_err), .acc_rdata(acc_rdata),
    .hit_addr(hit_addr), .hit_io(hit_io), .bar_hit(bar_hit)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  sz;
    logic [7:0]  off;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        eerr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd4, 8'h00, 32'h0, 32'h5A17C0DE, 1'b0, 8'd1},  // R1 ids
    '{1'b0, 3'd4, 8'h08, 32'h0, 32'h02800003, 1'b0, 8'd1},  // R1 class
    '{1'b0, 3'd4, 8'h3C, 32'h0, 32'h20080100, 1'b0, 8'd1},  // R1 intr dword
    '{1'b0, 3'd4, 8'h10, 32'h0, 32'h00000001, 1'b0, 8'd1},  // R1 io bar reset
    '{1'b0, 3'd4, 8'h18, 32'h0, 32'h00000008, 1'b0, 8'd1},  // R1 mem bar reset
    '{1'b0, 3'd4, 8'h2C, 32'h0, 32'h56781234, 1'b0, 8'd1},  // R1 subsystem
    '{1'b0, 3'd2, 8'h01, 32'h0, 32'h000017C0, 1'b0, 8'd2},  // R2 straddle
    '{1'b0, 3'd1, 8'h0A, 32'h0, 32'h00000080, 1'b0, 8'd2},  // R2 byte
    '{1'b0, 3'd4, 8'h34, 32'h0, 32'h00000000, 1'b0, 8'd2},  // R2 reserved
    '{1'b1, 3'd1, 8'h3C, 32'h0B, 32'h0, 1'b0, 8'd3},        // R3 line
    '{1'b1, 3'd1, 8'h3D, 32'h77, 32'h0, 1'b0, 8'd3},        // R3 pin ignored
    '{1'b0, 3'd2, 8'h3C, 32'h0, 32'h0000010B, 1'b0, 8'd3},
    '{1'b1, 3'd1, 8'h0C, 32'h10, 32'h0, 1'b0, 8'd3},
    '{1'b1, 3'd1, 8'h0D, 32'h40, 32'h0, 1'b0, 8'd3},
    '{1'b0, 3'd2, 8'h0C, 32'h0, 32'h00004010, 1'b0, 8'd3},
    '{1'b1, 3'd1, 8'h00, 32'hFF, 32'h0, 1'b0, 8'd3},        // R3 vendor ignored
    '{1'b0, 3'd1, 8'h00, 32'h0, 32'h000000DE, 1'b0, 8'd3},
    '{1'b1, 3'd2, 8'h04, 32'h0003, 32'h0, 1'b0, 8'd4},      // R4 command
    '{1'b1, 3'd2, 8'h06, 32'h0210, 32'h0, 1'b0, 8'd4},      // R4 status
    '{1'b0, 3'd4, 8'h04, 32'h0, 32'h02100003, 1'b0, 8'd4},
    '{1'b1, 3'd4, 8'h04, 32'hFFFF0007, 32'h0, 1'b0, 8'd4},  // R4 wide cmd
    '{1'b0, 3'd4, 8'h04, 32'h0, 32'h02100007, 1'b0, 8'd4},
    '{1'b1, 3'd4, 8'h10, 32'hFFFFFFFF, 32'h0, 1'b0, 8'd5},  // R5 io probe
    '{1'b0, 3'd4, 8'h10, 32'h0, 32'hFFFFFF01, 1'b0, 8'd5},
    '{1'b1, 3'd4, 8'h14, 32'hFFFFFFFF, 32'h0, 1'b0, 8'd5},  // R5 mem probe
    '{1'b0, 3'd4, 8'h14, 32'h0, 32'hFFFFF000, 1'b0, 8'd5},
    '{1'b1, 3'd4, 8'h18, 32'hFFFFFFFF, 32'h0, 1'b0, 8'd5},
    '{1'b0, 3'd4, 8'h18, 32'h0, 32'hFFFF0008, 1'b0, 8'd5},
    '{1'b1, 3'd4, 8'h10, 32'h0000A5FE, 32'h0, 1'b0, 8'd6},  // R6 io base
    '{1'b0, 3'd4, 8'h10, 32'h0, 32'h0000A5FD, 1'b0, 8'd6},
    '{1'b1, 3'd4, 8'h14, 32'h12345678, 32'h0, 1'b0, 8'd6},  // R6 mem base
    '{1'b0, 3'd4, 8'h14, 32'h0, 32'h12345670, 1'b0, 8'd6},
    '{1'b1, 3'd4, 8'h18, 32'h0000000F, 32'h0, 1'b0, 8'd6},
    '{1'b0, 3'd4, 8'h18, 32'h0, 32'h00000008, 1'b0, 8'd6},
    '{1'b1, 3'd4, 8'h30, 32'hFFFFFFFE, 32'h0, 1'b0, 8'd7},  // R7 rom probe
    '{1'b0, 3'd4, 8'h30, 32'h0, 32'hFFFFFFFF, 1'b0, 8'd7},
    '{1'b1, 3'd4, 8'h30, 32'h000C0001, 32'h0, 1'b0, 8'd7},
    '{1'b0, 3'd4, 8'h30, 32'h0, 32'h000C0001, 1'b0, 8'd7},
    '{1'b1, 3'd4, 8'h00, 32'hFFFFFFFF, 32'h0, 1'b0, 8'd12}, // R12 id ignored
    '{1'b0, 3'd4, 8'h00, 32'h0, 32'h5A17C0DE, 1'b0, 8'd12},
    '{1'b0, 3'd1, 8'h40, 32'h0, 32'h0, 1'b1, 8'd8},         // R8 above header
    '{1'b1, 3'd4, 8'h3E, 32'hAAAAAAAA, 32'h0, 1'b1, 8'd8},  // R8 crosses end
    '{1'b0, 3'd4, 8'h3C, 32'h0, 32'h2008010B, 1'b0, 8'd8},
    '{1'b1, 3'd3, 8'h3C, 32'h55, 32'h0, 1'b1, 8'd9},        // R9 size 3
    '{1'b0, 3'd1, 8'h3C, 32'h0, 32'h0000000B, 1'b0, 8'd9},
    '{1'b0, 3'd0, 8'h00, 32'h0, 32'h0, 1'b1, 8'd9}          // R9 size 0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [2:0] sz, input logic [7:0] off,
                        input logic [31:0] wd);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_size = sz; acc_offset = off; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic hit_chk(input logic [31:0] a, input logic io, input logic [5:0] exp, input string tag);
    @(negedge clk);
    hit_addr = a; hit_io = io;
    @(negedge clk);
    chk(tag, {26'h0, bar_hit}, {26'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset ack", {31'h0, acc_ack}, 32'h0);
    chk("R1 reset err", {31'h0, acc_err}, 32'h0);
    chk("R1 reset hit", {26'h0, bar_hit}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].sz, VEC[i].off, VEC[i].wd);
      chk("R10 ack", {31'h0, acc_ack}, 32'h1);
      chk($sformatf("R%0d vec %0d err", VEC[i].req, i), {31'h0, acc_err}, {31'h0, VEC[i].eerr});
      if (!VEC[i].wr)
        chk($sformatf("R%0d vec %0d data", VEC[i].req, i), acc_rdata, VEC[i].exp);
    end
    @(negedge clk);
    chk("R10 idle ack", {31'h0, acc_ack}, 32'h0);

    // R11: command holds 0x0007, io base 0xA500/256, mem base 0x12345000/4K
    hit_chk(32'h0000A57F, 1'b1, 6'b000001, "R11 io hit");
    hit_chk(32'h12345FFC, 1'b0, 6'b000010, "R11 mem hit");
    hit_chk(32'h12346000, 1'b0, 6'b000000, "R11 past end");
    hit_chk(32'h0000A57F, 1'b0, 6'b000000, "R11 space mismatch");
    access(1'b1, 3'd2, 8'h04, 32'h0002);
    hit_chk(32'h0000A500, 1'b1, 6'b000000, "R11 io disabled");
    hit_chk(32'h12345000, 1'b0, 6'b000010, "R11 mem enabled");
    access(1'b1, 3'd2, 8'h04, 32'h0000);
    hit_chk(32'h12345000, 1'b0, 6'b000000, "R11 mem disabled");

    // R1: a mid-run reset restores writable fields
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    access(1'b0, 3'd1, 8'h3C, 32'h0);
    chk("R1 line after reset", acc_rdata, 32'h0);
    access(1'b0, 3'd4, 8'h10, 32'h0);
    chk("R1 bar after reset", acc_rdata, 32'h00000001);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule